// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Divider

This block divides two 32-bit integers, signed or unsigned, over several clock cycles. How long it takes depends on how large the dividend is. A single-cycle start pulse supplies the dividend, the divisor and a mode bit. The block then takes the magnitude of each operand. It counts the leading zeros of the dividend magnitude and shifts the dividend left so that its first significant bit is on top. After that it runs one restoring quotient step per significant bit. A final cycle applies the result signs, and the special cases are resolved there too.

The total busy window is one setup cycle, plus one cycle per significant dividend bit, plus one fix-up cycle. A small dividend therefore finishes early. A dividend whose magnitude has its top bit set takes the full 34 cycles.

The surrounding pipeline stage stalls while `busy_o` is high. One cycle after the window ends, `done_o` pulses once. Quotient and remainder stay on the outputs until the next result replaces them. A following divide must wait for the window to close. It may be started in the same cycle that `done_o` is high.

Top module: `eterm_div`

## Requirements
- R1: After a start is accepted at a clock edge, `busy_o` is high for exactly 32 − CLZ(|dividend|) + 2 cycles, beginning in the cycle after that edge. The worst case is 34 cycles, reached when the dividend magnitude has bit 31 set.
- R2: With `signed_i` = 0 and a nonzero divisor, the quotient is the floor of dividend / divisor and the remainder is dividend mod divisor, both taken as unsigned 32-bit values.
- R3: With `signed_i` = 1 and a nonzero divisor, both operands are taken as two's complement. The quotient magnitude is |a| / |b|, and it is negated when the operand signs differ. The remainder is |a| mod |b| and carries the sign of the dividend. Dividing −2^31 by −1 gives 0x8000_0000 with remainder 0.
- R4: A zero dividend with a nonzero divisor costs 2 busy cycles and gives quotient 0 and remainder 0.
- R5: A zero divisor gives quotient 0xFFFF_FFFF and returns the dividend unchanged as the remainder, in either mode. The busy length still follows R1, so 0 / 0 takes 2 cycles.
- R6: A start pulse while `busy_o` is high is ignored. It neither changes the operands in flight nor lengthens the window.
- R7: `done_o` is high for exactly one cycle. That cycle immediately follows the last busy cycle, and `busy_o` is low in it.
- R8: `quotient_o` and `remainder_o` change only in a cycle where `done_o` is high, and they hold their value otherwise.
- R9: While `rst_ni` is low, `busy_o` and `done_o` are low and both results are zero.
- R10: A start given in the `done_o` cycle is accepted, so divides can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; sampled only when not busy |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend, sampled with the start |
| divisor_i | input | 32 | Divisor, sampled with the start |
| busy_o | output | 1 | High for the whole divide window |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| quotient_o | output | 32 | Quotient of the last completed divide |
| remainder_o | output | 32 | Remainder of the last completed divide |

## Verification
The assertions assume only that the operands and the mode bit are valid in a cycle where `start_i` is high and `busy_o` is low. They assume nothing about `start_i` at other times. A start during the busy window is legal and must be ignored. The stimulus drives every input at the falling clock edge, so the block always samples settled values. It deliberately pulses `start_i` with fresh operands in the middle of a divide, and it restarts in the `done_o` cycle. It also scrambles the operand inputs whenever no start is offered. The ignore rule and the capture-once rule are therefore exercised rather than assumed.

// File: rtl/eterm_div_pkg.sv
package eterm_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIX   = 2'd3
  } div_state_e;
endpackage

// File: rtl/div_lzc.sv
module div_lzc #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] zeros_o
);
  logic [W-1:0] seen;

  // seen[i]: some bit at or above i is set
  for (genvar i = 0; i < W; i++) begin : g_seen
    assign seen[i] = |val_i[W-1:i];
  end

  assign zeros_o = CW'($countones(~seen));
endmodule

// File: rtl/div_mag.sv
module div_mag #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         neg_i,
  output logic [W-1:0] val_o
);
  assign val_o = neg_i ? (~val_i + W'(1)) : val_i;
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic         bit_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic         qbit_o
);
  logic [W:0] shifted;
  logic [W:0] diff;

  assign shifted = {rem_i, bit_i};
  assign diff    = shifted - {1'b0, dvs_i};
  assign qbit_o  = ~diff[W];
  assign rem_o   = qbit_o ? diff[W-1:0] : shifted[W-1:0];
endmodule

// File: rtl/eterm_div.sv
module eterm_div
  import eterm_div_pkg::*;
#(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o
);
  localparam int NMAG = 4;

  div_state_e   state_q;
  logic [W-1:0] op_a_q, op_b_q;
  logic         sgn_q;
  logic [W-1:0] dvs_q, dvd_q, quo_q, rem_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0] quo_o_q, rem_o_q;
  logic         done_q;

  logic [W-1:0] mag_in  [NMAG];
  logic         mag_neg [NMAG];
  logic [W-1:0] mag_out [NMAG];

  logic [CW-1:0] clz;
  logic [CW-1:0] iters;
  logic [W-1:0]  step_rem;
  logic          step_q;

  // 0/1: operand magnitudes, 2/3: result sign fix-up
  assign mag_in[0]  = op_a_q;
  assign mag_neg[0] = sgn_q & op_a_q[W-1];
  assign mag_in[1]  = op_b_q;
  assign mag_neg[1] = sgn_q & op_b_q[W-1];
  assign mag_in[2]  = quo_q;
  assign mag_neg[2] = sgn_q & (op_a_q[W-1] ^ op_b_q[W-1]);
  assign mag_in[3]  = rem_q;
  assign mag_neg[3] = sgn_q & op_a_q[W-1];

  for (genvar g = 0; g < NMAG; g++) begin : g_mag
    div_mag #(.W(W)) u_mag (
      .val_i (mag_in[g]),
      .neg_i (mag_neg[g]),
      .val_o (mag_out[g])
    );
  end

  div_lzc #(.W(W)) u_lzc (
    .val_i   (mag_out[0]),
    .zeros_o (clz)
  );

  assign iters = CW'(W) - clz;

  div_step #(.W(W)) u_step (
    .rem_i  (rem_q),
    .bit_i  (dvd_q[W-1]),
    .dvs_i  (dvs_q),
    .rem_o  (step_rem),
    .qbit_o (step_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_a_q  <= '0;
      op_b_q  <= '0;
      sgn_q   <= 1'b0;
      dvs_q   <= '0;
      dvd_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      quo_o_q <= '0;
      rem_o_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            op_a_q  <= dividend_i;
            op_b_q  <= divisor_i;
            sgn_q   <= signed_i;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          dvd_q   <= mag_out[0] << clz;
          dvs_q   <= mag_out[1];
          quo_q   <= '0;
          rem_q   <= '0;
          cnt_q   <= iters;
          state_q <= (iters == '0) ? ST_FIX : ST_ITER;
        end
        ST_ITER: begin
          dvd_q <= dvd_q << 1;
          quo_q <= {quo_q[W-2:0], step_q};
          rem_q <= step_rem;
          cnt_q <= cnt_q - CW'(1);
          if (cnt_q == CW'(1)) state_q <= ST_FIX;
        end
        ST_FIX: begin
          if (op_b_q == '0) begin
            quo_o_q <= '1;
            rem_o_q <= op_a_q;
          end else begin
            quo_o_q <= mag_out[2];
            rem_o_q <= mag_out[3];
          end
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign quotient_o  = quo_o_q;
  assign remainder_o = rem_o_q;

  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R1
  AST_MIN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o); // R4
  AST_ITER_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ITER) |-> (cnt_q != '0 && cnt_q <= CW'(W))); // R1
  AST_OPS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(op_a_q) && $stable(op_b_q) && $stable(sgn_q))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R7
  AST_RES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o))); // R8
endmodule

// File: tb/eterm_div_bench.sv
module eterm_div_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sgn = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic busy, done;
  logic [W-1:0] quo, rem;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  eterm_div u_eterm_div (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .signed_i    (sgn),
    .dividend_i  (a),
    .divisor_i   (b),
    .busy_o      (busy),
    .done_o      (done),
    .quotient_o  (quo),
    .remainder_o (rem)
  );

  function automatic logic [W-1:0] absval(logic [W-1:0] v, logic s);
    return (s && v[W-1]) ? -v : v;
  endfunction

  function automatic int exp_len(logic [W-1:0] x, logic s);
    logic [W-1:0] m = absval(x, s);
    int sig = 0;
    for (int i = 0; i < W; i++) if (m[i]) sig = i + 1;
    return sig + 2;
  endfunction

  task automatic exp_res(input logic [W-1:0] x, input logic [W-1:0] y, input logic s,
                         output logic [W-1:0] q, output logic [W-1:0] r);
    logic [W-1:0] mx, my;
    if (y == '0) begin
      q = '1; r = x;
    end else begin
      mx = absval(x, s);
      my = absval(y, s);
      q = mx / my;
      r = mx % my;
      if (s && (x[W-1] != y[W-1])) q = -q;
      if (s && x[W-1]) r = -r;
    end
  endtask

  // reference model
  int m_cnt = 0;
  bit m_done = 0;
  logic [W-1:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;
  string m_tag = "R8", p_tag = "R2";

  always @(posedge clk) begin
    bit was_done;
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_q = '0; m_r = '0;
    end else begin
      was_done = m_done;
      m_done = 0;
      if (m_cnt == 0) begin
        if (start) begin
          exp_res(a, b, sgn, p_q, p_r);
          m_cnt = exp_len(a, sgn);
          if (was_done)        p_tag = "R10";
          else if (b == '0)    p_tag = "R5";
          else if (a == '0)    p_tag = "R4";
          else if (sgn)        p_tag = "R3";
          else                 p_tag = "R2";
        end
      end else begin
        if (start) p_tag = "R6";
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1; m_q = p_q; m_r = p_r; m_tag = p_tag;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (m_cnt > 0), "R1", "busy", W'(busy), W'(m_cnt > 0));
      chk(done == m_done, "R7", "done", W'(done), W'(m_done));
      chk(quo == m_q, m_done ? m_tag : "R8", "quotient", quo, m_q);
      chk(rem == m_r, m_done ? m_tag : "R8", "remainder", rem, m_r);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input logic s,
                        input bit b2b, input bit poke);
    if (b2b) begin
      while (!done) @(negedge clk);
    end else begin
      while (busy) @(negedge clk);
    end
    start = 1'b1; a = x; b = y; sgn = s;
    @(negedge clk);
    start = 1'b0; a = $urandom; b = $urandom; sgn = $urandom;
    if (poke) begin
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !done, "R9", "busy/done in reset", W'({busy, done}), '0);
    chk(quo == '0 && rem == '0, "R9", "results in reset", quo | rem, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(32'd100, 32'd7, 1'b0, 0, 0);            // R2
    run_op(32'd0, 32'd5, 1'b0, 0, 0);              // R4
    run_op(32'd0, 32'd0, 1'b1, 0, 0);              // R5 zero by zero
    run_op(32'h8000_0000, 32'd3, 1'b0, 0, 0);      // R1 worst case 34
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, 0);
    run_op(-32'sd7, 32'd2, 1'b1, 0, 0);            // R3
    run_op(32'd7, -32'sd2, 1'b1, 0, 0);            // R3
    run_op(-32'sd7, -32'sd2, 1'b1, 0, 0);          // R3
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 0, 0); // R3 overflow case
    run_op(32'd123, 32'd0, 1'b0, 0, 0);            // R5
    run_op(-32'sd5, 32'd0, 1'b1, 0, 0);            // R5
    run_op(32'd1, 32'd1, 1'b0, 0, 0);              // R1 three cycles
    run_op(32'd1000, 32'd3, 1'b0, 0, 1);           // R6 poke while busy
    run_op(32'd55, 32'd4, 1'b1, 1, 0);             // R10 back to back
    run_op(32'd0, 32'd9, 1'b0, 1, 0);              // R10 then R4

    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] x, y;
      x = $urandom >> ($urandom % 33);
      y = $urandom >> ($urandom % 33);
      if ($urandom % 16 == 0) y = '0;
      run_op(x, y, 1'($urandom), bit'($urandom % 4 == 0), bit'($urandom % 5 == 0));
    end

    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule